// File: doc/BRIEF.md
# Out-of-Order Issue Queue Scheduler

This block sits between register rename and three execution units: two arithmetic units and one memory unit. Rename hands it one instruction per cycle. Each instruction carries:
- an op class, which selects an arithmetic unit or the memory unit;
- two physical source tags;
- one physical destination tag.

The scheduler holds each instruction until both of its source registers are available. It then grants it to a free unit of the right class and reports the destination tag of every grant.

Readiness is kept per physical register, and each class of unit wakes its consumers on its own schedule:
- An arithmetic result is usable by a consumer that issues in the very next cycle.
- The memory unit is a pipeline of several stages. A consumer of a load may issue only once the load has passed through all of those stages.

The entries are kept in age order, so every selection favours the oldest ready work. When every entry is occupied, the block raises a full flag and refuses new instructions.

Top module: `iq_sched`

## Requirements
- R1: After reset no grant is raised and `full` is low. Physical tags 1 through BOOT_READY (15 by default) are ready. Tag 0 and every tag above BOOT_READY are not ready.
- R2: An instruction accepted in cycle t is granted no earlier than cycle t+1. It is granted only in a cycle where both of its source tags are ready.
- R3: In one cycle there are at most two arithmetic grants and at most one memory grant. Arithmetic slot 0 is filled before slot 1.
- R4: Grants are as many as possible: while a ready arithmetic instruction waits, slot 0 is granted, and both slots are granted when at least two ready arithmetic instructions wait. A ready memory instruction is always granted.
- R5: When more instructions of one class are ready than there are slots, the oldest accepted instructions win. Slot 0 takes the older of the two arithmetic grants.
- R6: An arithmetic grant in cycle c makes its destination tag ready from cycle c+1.
- R7: A memory grant in cycle c makes its destination tag ready from cycle c+MEM_LAT (c+3 by default), and not earlier.
- R8: Accepting an instruction marks its destination tag not ready, even if that tag was ready before. The tag stays not ready until this instruction's own wakeup.
- R9: `full` is high in a cycle whose starting occupancy equals DEPTH. An `alloc_valid` presented in such a cycle is dropped, so that instruction is never granted.
- R10: A grant carries the destination tag of the granted instruction. That instruction leaves the queue and is not granted again.
- R11: `alloc_mem` = 1 marks a memory-class instruction (loads with a base register plus an offset), which goes only to the memory unit. `alloc_mem` = 0 marks an arithmetic instruction (add, subtract, multiply), which goes only to the arithmetic units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Rename presents an instruction this cycle |
| alloc_mem | input | 1 | Op class: 1 memory, 0 arithmetic |
| alloc_src0 | input | TAG_W | First source physical tag |
| alloc_src1 | input | TAG_W | Second source physical tag |
| alloc_dst | input | TAG_W | Destination physical tag |
| full | output | 1 | All entries occupied; allocation is dropped |
| alu_valid | output | 2 | Grant for arithmetic slot 1 and slot 0 |
| alu_tag | output | 2 x TAG_W | Destination tag of each arithmetic grant |
| mem_valid | output | 1 | Grant for the memory unit |
| mem_tag | output | TAG_W | Destination tag of the memory grant |

## Verification
The bench builds the scheduler with DEPTH = 4 and keeps the default tag width, register count, boot-ready range and memory latency of three. The small depth lets the queue fill with only four waiting instructions, so the full flag, the dropped allocation and contention for the two arithmetic slots can all be reached within about ten cycles. The default latency makes the load-to-consumer gap three cycles. This gives room to check that a consumer is held back in the two cycles before its wakeup as well as released in the cycle of the wakeup.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic {
        OPC_ALU = 1'b0,
        OPC_MEM = 1'b1
    } opc_e;

    localparam int ALU_PORTS = 2;

endpackage

// File: rtl/iq_ready_sb.sv
module iq_ready_sb #(
    parameter int NUM_PREG   = 64,
    parameter int TAG_W      = 6,
    parameter int BOOT_READY = 15,
    parameter int MEM_LAT    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            alu_wake_v,
    input  logic [1:0][TAG_W-1:0] alu_wake_tag,
    input  logic                  mem_wake_v,
    input  logic [TAG_W-1:0]      mem_wake_tag,
    input  logic                  claim_v,
    input  logic [TAG_W-1:0]      claim_tag,
    output logic [NUM_PREG-1:0]   rdy
);
    localparam int PIPE = MEM_LAT - 1;

    function automatic logic [NUM_PREG-1:0] boot_mask();
        logic [NUM_PREG-1:0] m;
        for (int i = 0; i < NUM_PREG; i++) m[i] = (i >= 1) && (i <= BOOT_READY);
        return m;
    endfunction

    localparam logic [NUM_PREG-1:0] BOOT = boot_mask();

    typedef struct packed {
        logic [NUM_PREG-1:0]        rdy;
        logic [PIPE-1:0]            pv;
        logic [PIPE-1:0][TAG_W-1:0] pt;
    } sb_t;

    sb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // load wakeup travels down a delay line, one stage per cycle
        s_d.pv[0] = mem_wake_v;
        s_d.pt[0] = mem_wake_tag;
        for (int i = 1; i < PIPE; i++) begin
            s_d.pv[i] = s_q.pv[i-1];
            s_d.pt[i] = s_q.pt[i-1];
        end
        if (s_q.pv[PIPE-1]) s_d.rdy[s_q.pt[PIPE-1]] = 1'b1;
        for (int k = 0; k < 2; k++) begin
            if (alu_wake_v[k]) s_d.rdy[alu_wake_tag[k]] = 1'b1;
        end
        // a fresh producer claim overrides any wakeup of the same tag
        if (claim_v) s_d.rdy[claim_tag] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.rdy <= BOOT;
            s_q.pv  <= '0;
            s_q.pt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdy = s_q.rdy;

    p_alu_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alu_wake_v[0] && !(claim_v && claim_tag == alu_wake_tag[0])
        |=> rdy[$past(alu_wake_tag[0])]);

    p_mem_not_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wake_v && !rdy[mem_wake_tag]
        && !(alu_wake_v[0] && alu_wake_tag[0] == mem_wake_tag)
        && !(alu_wake_v[1] && alu_wake_tag[1] == mem_wake_tag)
        && !(s_q.pv[PIPE-1] && s_q.pt[PIPE-1] == mem_wake_tag)
        |=> !rdy[$past(mem_wake_tag)]);

    p_claim_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        claim_v |=> !rdy[$past(claim_tag)]);

endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
    parameter int DEPTH     = 8,
    parameter int ALU_PORTS = 2,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]                cand_alu,
    input  logic [DEPTH-1:0]                cand_mem,
    output logic [ALU_PORTS-1:0]            alu_v,
    output logic [ALU_PORTS-1:0][IDX_W-1:0] alu_idx,
    output logic                            mem_v,
    output logic [IDX_W-1:0]                mem_idx
);
    // index 0 holds the oldest entry, so the lowest set bit wins
    always_comb begin
        logic [DEPTH-1:0] left;
        left    = cand_alu;
        alu_v   = '0;
        alu_idx = '0;
        for (int k = 0; k < ALU_PORTS; k++) begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (left[i]) begin
                    alu_v[k]   = 1'b1;
                    alu_idx[k] = IDX_W'(i);
                end
            end
            if (alu_v[k]) left[alu_idx[k]] = 1'b0;
        end
        mem_v   = 1'b0;
        mem_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (cand_mem[i]) begin
                mem_v   = 1'b1;
                mem_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/iq_sched.sv
module iq_sched
    import iq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int TAG_W      = 6,
    parameter int NUM_PREG   = 64,
    parameter int BOOT_READY = 15,
    parameter int MEM_LAT    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_valid,
    input  logic                  alloc_mem,
    input  logic [TAG_W-1:0]      alloc_src0,
    input  logic [TAG_W-1:0]      alloc_src1,
    input  logic [TAG_W-1:0]      alloc_dst,
    output logic                  full,
    output logic [1:0]            alu_valid,
    output logic [1:0][TAG_W-1:0] alu_tag,
    output logic                  mem_valid,
    output logic [TAG_W-1:0]      mem_tag
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        opc_e             cls;
        logic [TAG_W-1:0] s0;
        logic [TAG_W-1:0] s1;
        logic [TAG_W-1:0] dst;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ents;
        logic [CNT_W-1:0] cnt;
    } q_t;

    q_t q_d, q_q;

    logic [NUM_PREG-1:0]            rdy;
    logic [DEPTH-1:0]               cand_alu, cand_mem, gone;
    logic [ALU_PORTS-1:0]           pk_alu_v;
    logic [ALU_PORTS-1:0][IDX_W-1:0] pk_alu_idx;
    logic                           pk_mem_v;
    logic [IDX_W-1:0]               pk_mem_idx;
    logic                           take;
    ent_t                           new_ent;

    assign full    = (q_q.cnt == CNT_W'(DEPTH));
    assign take    = alloc_valid && !full;
    assign new_ent = '{cls: opc_e'(alloc_mem), s0: alloc_src0, s1: alloc_src1, dst: alloc_dst};

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic occ, ok;
            occ = CNT_W'(i) < q_q.cnt;
            ok  = rdy[q_q.ents[i].s0] && rdy[q_q.ents[i].s1];
            cand_alu[i] = occ && ok && (q_q.ents[i].cls == OPC_ALU);
            cand_mem[i] = occ && ok && (q_q.ents[i].cls == OPC_MEM);
        end
    end

    iq_pick #(.DEPTH(DEPTH), .ALU_PORTS(ALU_PORTS)) pick_i (
        .cand_alu (cand_alu),
        .cand_mem (cand_mem),
        .alu_v    (pk_alu_v),
        .alu_idx  (pk_alu_idx),
        .mem_v    (pk_mem_v),
        .mem_idx  (pk_mem_idx)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            gone[i] = (pk_mem_v && pk_mem_idx == IDX_W'(i));
            for (int k = 0; k < ALU_PORTS; k++) begin
                if (pk_alu_v[k] && pk_alu_idx[k] == IDX_W'(i)) gone[i] = 1'b1;
            end
        end
    end

    // collapse survivors toward index 0 and append the new entry behind them
    always_comb begin
        logic [CNT_W-1:0] w;
        q_d = q_q;
        w   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < q_q.cnt && !gone[i]) begin
                q_d.ents[w[IDX_W-1:0]] = q_q.ents[i];
                w = w + 1'b1;
            end
        end
        if (take) begin
            q_d.ents[w[IDX_W-1:0]] = new_ent;
            w = w + 1'b1;
        end
        q_d.cnt = w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            alu_valid[k] = pk_alu_v[k];
            alu_tag[k]   = pk_alu_v[k] ? q_q.ents[pk_alu_idx[k]].dst : '0;
        end
        mem_valid = pk_mem_v;
        mem_tag   = pk_mem_v ? q_q.ents[pk_mem_idx].dst : '0;
    end

    iq_ready_sb #(
        .NUM_PREG(NUM_PREG), .TAG_W(TAG_W), .BOOT_READY(BOOT_READY), .MEM_LAT(MEM_LAT)
    ) sb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .alu_wake_v   (alu_valid),
        .alu_wake_tag (alu_tag),
        .mem_wake_v   (mem_valid),
        .mem_wake_tag (mem_tag),
        .claim_v      (take),
        .claim_tag    (alloc_dst),
        .rdy          (rdy)
    );

    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid[0] |-> rdy[q_q.ents[pk_alu_idx[0]].s0] && rdy[q_q.ents[pk_alu_idx[0]].s1]);

    p_slot_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid[1] |-> alu_valid[0]);

    p_work_conserve_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand_alu) |-> alu_valid[0]);

    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full && (alu_valid == 2'b00) && !mem_valid |=> full);

endmodule

// File: tb/iq_sched_tb.sv
`timescale 1ns/1ps
module iq_sched_tb_top;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0;
    logic             alloc_mem = 1'b0;
    logic [5:0]       alloc_src0 = '0;
    logic [5:0]       alloc_src1 = '0;
    logic [5:0]       alloc_dst = '0;
    logic             full;
    logic [1:0]       alu_valid;
    logic [1:0][5:0]  alu_tag;
    logic             mem_valid;
    logic [5:0]       mem_tag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    iq_sched #(.DEPTH(4)) dut_i (
        .clk, .rst_n, .alloc_valid, .alloc_mem, .alloc_src0, .alloc_src1,
        .alloc_dst, .full, .alu_valid, .alu_tag, .mem_valid, .mem_tag
    );

    // columns: valid, mem, src0, src1, dst | exp alu_valid, alu0, alu1, mem_v, mem_t, full
    // dependency chain with a load feeding a waiting subtract (R2 R6 R7 R10 R11)
    localparam int NV = 11;
    localparam int VECS [NV][11] = '{
        '{1, 0,  5,  6, 16,  0,  0,  0, 0,  0, 0},
        '{1, 1,  5,  5, 18,  1, 16,  0, 0,  0, 0},
        '{1, 0, 18,  7, 21,  0,  0,  0, 1, 18, 0},
        '{1, 0, 16,  7, 17,  0,  0,  0, 0,  0, 0},
        '{1, 0, 17,  9, 19,  1, 17,  0, 0,  0, 0},
        '{1, 0,  5,  7, 20,  3, 21, 19, 0,  0, 0},
        '{1, 0, 20, 19, 22,  1, 20,  0, 0,  0, 0},
        '{1, 1, 22, 22, 23,  1, 22,  0, 0,  0, 0},
        '{1, 0,  8, 16, 24,  0,  0,  0, 1, 23, 0},
        '{0, 0,  0,  0,  0,  1, 24,  0, 0,  0, 0},
        '{0, 0,  0,  0,  0,  0,  0,  0, 0,  0, 0}
    };

    task automatic step(input int av, input int am, input int s0, input int s1, input int d,
                        input int ev, input int e0, input int e1, input int emv, input int emt,
                        input int ef, input string req);
        bit ok;
        @(negedge clk);
        ok = (alu_valid == 2'(ev))
          && (!ev[0] || alu_tag[0] == 6'(e0))
          && (!ev[1] || alu_tag[1] == 6'(e1))
          && (mem_valid == emv[0])
          && (!emv[0] || mem_tag == 6'(emt))
          && (full == ef[0]);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got alu_v=%b t0=%0d t1=%0d mem_v=%b mt=%0d full=%b exp alu_v=%0d t0=%0d t1=%0d mem_v=%0d mt=%0d full=%0d",
                     req, alu_valid, alu_tag[0], alu_tag[1], mem_valid, mem_tag, full,
                     ev, e0, e1, emv, emt, ef);
        end
        alloc_valid = av[0];
        alloc_mem   = am[0];
        alloc_src0  = 6'(s0);
        alloc_src1  = 6'(s1);
        alloc_dst   = 6'(d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        alloc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no finish, exp finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int r = 0; r < NV; r++) begin
            step(VECS[r][0], VECS[r][1], VECS[r][2], VECS[r][3], VECS[r][4], VECS[r][5],
                 VECS[r][6], VECS[r][7], VECS[r][8], VECS[r][9], VECS[r][10],
                 "R2 R6 R7 R10 R11 table");
        end

        // R1: reset state, boot-ready tag 15 issues, tag 16 and tag 0 never ready
        do_reset();
        step(1,0,15, 1,44, 0, 0, 0,0, 0,0, "R1 reset");
        step(0,0, 0, 0, 0, 1,44, 0,0, 0,0, "R1 boot tag 15");
        step(1,0,16, 1,45, 0, 0, 0,0, 0,0, "R1");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R1 tag 16 not ready");
        step(1,0, 0, 1,46, 0, 0, 0,0, 0,0, "R1 tag 16 not ready");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R1 tag 0 not ready");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R1 tag 0 not ready");

        // R9 R3 R5 R7: fill the queue behind a load chain, dropped alloc, slot cap
        do_reset();
        step(1,1, 1, 1,30, 0, 0, 0,0, 0,0, "R9");
        step(1,1,30,30,35, 0, 0, 0,1,30,0, "R11 load grant");
        step(1,0,35, 1,31, 0, 0, 0,0, 0,0, "R7 not early");
        step(1,0,35, 2,32, 0, 0, 0,0, 0,0, "R7 not early");
        step(1,0,35, 3,33, 0, 0, 0,1,35,0, "R7 wake at c+3");
        step(1,1,35,35,34, 0, 0, 0,0, 0,0, "R7 not early");
        step(1,0, 1, 2,36, 0, 0, 0,0, 0,1, "R9 full raised");
        step(0,0, 0, 0, 0, 3,31,32,1,34,1, "R3 R5 two oldest alu");
        step(0,0, 0, 0, 0, 1,33, 0,0, 0,0, "R4 R10 leftover");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R9 dropped alloc never granted");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R9 dropped alloc never granted");

        // R5 R3: two ready loads, oldest first, one per cycle, alu in parallel
        do_reset();
        step(1,1, 1, 1,30, 0, 0, 0,0, 0,0, "R5");
        step(1,1,30,30,41, 0, 0, 0,1,30,0, "R5");
        step(1,1,30,30,42, 0, 0, 0,0, 0,0, "R5");
        step(1,0,30, 4,43, 0, 0, 0,0, 0,0, "R5");
        step(0,0, 0, 0, 0, 1,43, 0,1,41,0, "R5 R3 oldest load");
        step(0,0, 0, 0, 0, 0, 0, 0,1,42,0, "R5 second load");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R10 no repeat");

        // R8: reused boot-ready tag 5 is claimed by a load
        do_reset();
        step(1,1, 1, 1, 5, 0, 0, 0,0, 0,0, "R8");
        step(1,0, 5, 5,40, 0, 0, 0,1, 5,0, "R8");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R8 claimed tag not ready");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R8 claimed tag not ready");
        step(0,0, 0, 0, 0, 1,40, 0,0, 0,0, "R8 R7 released");
        step(0,0, 0, 0, 0, 0, 0, 0,0, 0,0, "R10");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule